// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block sits behind the command decoder of a serial memory slave and owns the write-enable latch and the writable bits of the status register. The decoder hands it one-cycle strobes: latch set, latch clear, the start of a status-write command, and a strobe for each data byte that has been fully shifted in. The block also watches the chip-select line and the active-low hardware write-protect pin. It decides whether a status write may go ahead, commits it when chip select rises, and then runs a busy period that stands in for the internal programming time.

Status bit 7 is the protect-enable bit. When it is 1, a low write-protect pin blocks status writes. When it is 0, the pin has no effect, so a board can tie the pin low and still write the register. If the pin drops while a status-write command is still open, that command is cancelled. Once the internal write has started, the pin no longer matters. The busy period is `BUSY_CYCLES` clock cycles long. The default corresponds to 5 ms at 125 MHz.

The status byte presented to the decoder carries busy in bit 0 and the write-enable latch in bit 1. Bits 7 to 2 are the stored register bits.

Top module: `swp_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and the commit strobe is low.
- R2: While not busy, a latch-set strobe makes status bit 1 read 1, and a latch-clear strobe makes it read 0; when both arrive in the same cycle, clear wins.
- R3: A status-write command that starts while status bit 1 is 0 leaves the status byte unchanged and produces no commit strobe.
- R4: A status write commits only on the clock edge that first samples chip select high after a command in which a complete data byte arrived. On that edge:
  - bits 7 to 2 take the first byte's bits 7 to 2;
  - the byte's bits 1 and 0 are ignored;
  - the commit strobe is high for exactly one cycle.
  
  A command that ends without a data byte commits nothing.
- R5: While status bit 7 is 1 and the write-protect pin is low, a status-write command is rejected and nothing commits.
- R6: While status bit 7 is 0, the write-protect pin has no effect; a status write with the pin held low commits normally.
- R7: With status bit 7 at 1, the write-protect pin going low at any point of an open status-write command cancels that command, even if the pin returns high before chip select rises.
- R8: After a commit, status bit 0 reads 1 for exactly `BUSY_CYCLES` cycles, and write-protect pin changes during that time do not alter the committed value.
- R9: While busy, latch-set, latch-clear and status-write strobes are ignored.
- R10: The write-enable latch clears on the same edge that ends the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low, synchronous to clk |
| wpN | input | 1 | Hardware write-protect pin, active low |
| setWel | input | 1 | Latch-set command strobe |
| clrWel | input | 1 | Latch-clear command strobe |
| wrStatStart | input | 1 | Status-write opcode decoded |
| byteValid | input | 1 | A full data byte is on byteData |
| byteData | input | 8 | Received data byte, MSB first already assembled |
| statusOut | output | 8 | Status byte: bit 7 protect enable, bits 6..2 stored, bit 1 write-enable latch, bit 0 busy |
| commitStb | output | 1 | One-cycle pulse when a status write commits |

## Verification
A stale pending flag or a protect check that misses a short pin pulse shows up as a spurious commit strobe. On the edge after chip select rises, the status bits then change when they should not. An off-by-one in the busy counter moves the fall of bit 0, and the clearing of bit 1 with it, by one cycle at the end of the write. A latch that reacts to strobes during busy shows in bit 1 on the edge after the strobe. The bench compares the whole status byte and the commit strobe against a behavioural model on every cycle, so each of these faults is caught within one clock of its appearance.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int STAT_W    = 8;
  localparam int STORE_LO  = 2;
  localparam int STORE_W   = STAT_W - STORE_LO;
  localparam int PEN_IDX   = STORE_W - 1;

  typedef struct packed {
    logic               setWel;
    logic               clrWel;
    logic               commit;
    logic [STORE_W-1:0] newBits;
  } swp_strobe_t;
endpackage

// File: rtl/swp_ctrl.sv
module swp_ctrl
  import swp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        wpN,
  input  logic        setWel,
  input  logic        clrWel,
  input  logic        wrStatStart,
  input  logic        byteValid,
  input  logic [STAT_W-1:0] byteData,
  input  logic        busy,
  input  logic        wel,
  input  logic        protEn,
  output swp_strobe_t str
);
  logic csPrev;
  logic pending;
  logic hasByte;
  logic [STORE_W-1:0] dataHold;
  logic csRise;
  logic blocked;
  logic startOk;

  assign csRise  = !csPrev && csN;
  assign blocked = protEn && !wpN;
  assign startOk = wrStatStart && !csN && !busy && wel && !blocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      pending  <= 1'b0;
      hasByte  <= 1'b0;
      dataHold <= '0;
    end else begin
      csPrev <= csN;
      if (csRise || (pending && blocked)) begin
        pending <= 1'b0;
        hasByte <= 1'b0;
      end else if (startOk) begin
        pending <= 1'b1;
        hasByte <= 1'b0;
      end else if (pending && !csN && byteValid && !hasByte) begin
        hasByte  <= 1'b1;
        dataHold <= byteData[STAT_W-1:STORE_LO];
      end
    end
  end

  always_comb begin
    str         = '0;
    str.setWel  = setWel && !busy;
    str.clrWel  = clrWel && !busy;
    str.commit  = csRise && pending && hasByte && !blocked;
    str.newBits = dataHold;
  end

  assert_no_pend_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !busy);
  assert_commit_needs_wel_R3: assert property (@(posedge clk) disable iff (!rstN)
    str.commit |-> wel);
  assert_commit_unprot_R5: assert property (@(posedge clk) disable iff (!rstN)
    str.commit |-> (wpN || !protEn));
endmodule

// File: rtl/swp_dp.sv
module swp_dp
  import swp_pkg::*;
#(
  parameter int BUSY_CYCLES = 625000
) (
  input  logic        clk,
  input  logic        rstN,
  input  swp_strobe_t str,
  output logic        busy,
  output logic        wel,
  output logic        protEn,
  output logic [STAT_W-1:0] statusOut,
  output logic        commitStb
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]   cnt;
  logic [STORE_W-1:0] storeBits;

  assign busy      = cnt != '0;
  assign protEn    = storeBits[PEN_IDX];
  assign statusOut = {storeBits, wel, busy};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      storeBits <= '0;
      wel       <= 1'b0;
      commitStb <= 1'b0;
    end else begin
      commitStb <= str.commit;
      if (busy) begin
        cnt <= cnt - CNT_ONE;
        if (cnt == CNT_ONE) wel <= 1'b0;
      end else if (str.commit) begin
        cnt       <= CNT_LOAD;
        storeBits <= str.newBits;
      end else if (str.clrWel) begin
        wel <= 1'b0;
      end else if (str.setWel) begin
        wel <= 1'b1;
      end
    end
  end

  assert_commit_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (busy && wel));
  assert_wel_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (wel == $past(wel)));
  assert_busy_end_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);
  assert_bits_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !commitStb |-> $stable(storeBits));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LOAD);
endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int BUSY_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       wpN,
  input  logic       setWel,
  input  logic       clrWel,
  input  logic       wrStatStart,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output logic [7:0] statusOut,
  output logic       commitStb
);
  swp_strobe_t str;
  logic busy;
  logic wel;
  logic protEn;

  swp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN),
    .setWel(setWel), .clrWel(clrWel), .wrStatStart(wrStatStart),
    .byteValid(byteValid), .byteData(byteData),
    .busy(busy), .wel(wel), .protEn(protEn), .str(str)
  );

  swp_dp #(.BUSY_CYCLES(BUSY_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .busy(busy), .wel(wel), .protEn(protEn),
    .statusOut(statusOut), .commitStb(commitStb)
  );
endmodule

// File: tb/swp_guard_bench.sv
module swp_guard_bench;
  localparam int BUSY = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic wpN = 1'b1;
  logic setWel = 1'b0;
  logic clrWel = 1'b0;
  logic wrStatStart = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic [7:0] statusOut;
  logic commitStb;

  always #4 clk = ~clk;

  swp_guard #(.BUSY_CYCLES(BUSY)) u_swp_guard (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN),
    .setWel(setWel), .clrWel(clrWel), .wrStatStart(wrStatStart),
    .byteValid(byteValid), .byteData(byteData),
    .statusOut(statusOut), .commitStb(commitStb)
  );

  int nVec = 0;
  int nBad = 0;
  string req = "R1";
  bit checking = 1'b0;

  // behavioural reference
  int mWel, mBits, mCnt, mPend, mHas, mData, mCsPrev, mCommit;
  initial begin
    mWel = 0; mBits = 0; mCnt = 0; mPend = 0; mHas = 0; mData = 0; mCsPrev = 1; mCommit = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mWel = 0; mBits = 0; mCnt = 0; mPend = 0; mHas = 0; mData = 0; mCsPrev = 1; mCommit = 0;
    end else begin
      automatic bit wasBusy = (mCnt > 0);
      automatic bit prot = ((mBits >> 5) & 1) == 1 && wpN == 1'b0;
      automatic bit rise = (mCsPrev == 0) && csN;
      automatic bit doCommit = 0;
      if (rise) begin
        doCommit = mPend && mHas && !prot;
        mPend = 0; mHas = 0;
      end else if (mPend && prot) begin
        mPend = 0; mHas = 0;
      end else if (wrStatStart && !csN && !wasBusy && mWel == 1 && !prot) begin
        mPend = 1; mHas = 0;
      end else if (mPend && !csN && byteValid && !mHas) begin
        mHas = 1; mData = byteData >> 2;
      end
      if (wasBusy) begin
        mCnt = mCnt - 1;
        if (mCnt == 0) mWel = 0;
      end else if (doCommit) begin
        mCnt = BUSY; mBits = mData;
      end else if (clrWel) mWel = 0;
      else if (setWel) mWel = 1;
      mCommit = doCommit;
      mCsPrev = csN;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      automatic logic [7:0] expS = {mBits[5:0], mWel[0], mCnt > 0};
      nVec++;
      if (statusOut !== expS || commitStb !== mCommit[0]) begin
        nBad++;
        $display("FAIL %s: status=%02h commit=%0b expected status=%02h commit=%0b",
                 req, statusOut, commitStb, expS, mCommit[0]);
      end
    end
  end

  // explicit value check against a fixed expectation
  task automatic expectStat(input string r, input logic [7:0] exp);
    nVec++;
    if (statusOut !== exp) begin
      nBad++;
      $display("FAIL %s: status=%02h expected %02h", r, statusOut, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0;
  endtask

  // full status-write command: optional byte, optional wp glitch
  task automatic wrStat(input logic [7:0] d, input bit giveByte, input bit glitch);
    csN = 1'b0; tick(1);
    wrStatStart = 1'b1; tick(1); wrStatStart = 1'b0;
    tick(2);
    if (giveByte) begin
      byteData = d; byteValid = 1'b1; tick(1); byteValid = 1'b0;
    end
    if (glitch) begin
      wpN = 1'b0; tick(1); wpN = 1'b1;
    end
    tick(2);
    csN = 1'b1; tick(2);
  endtask

  initial begin : watchdog
    #1000000;
    nBad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    checking = 1'b1;
    req = "R1"; tick(1); expectStat("R1", 8'h00);
    tick(3);

    req = "R2"; pulse(setWel); tick(1); expectStat("R2", 8'h02);
    pulse(clrWel); tick(1); expectStat("R2", 8'h00);
    pulse(setWel); setWel = 1'b1; clrWel = 1'b1; tick(1); setWel = 1'b0; clrWel = 1'b0;
    tick(1); expectStat("R2", 8'h00);

    req = "R3"; wrStat(8'hFC, 1'b1, 1'b0); tick(2); expectStat("R3", 8'h00);

    req = "R4"; pulse(setWel); wrStat(8'hFC, 1'b0, 1'b0); tick(1); expectStat("R4", 8'h02);
    wrStat(8'hBF, 1'b1, 1'b0);
    expectStat("R4", 8'hBF);

    req = "R8"; wpN = 1'b0; tick(5); wpN = 1'b1;
    req = "R9"; pulse(clrWel); tick(1); pulse(setWel); wrStat(8'h00, 1'b1, 1'b0);
    req = "R10"; tick(BUSY); expectStat("R10", 8'hBC);

    req = "R5"; wpN = 1'b0; pulse(setWel); wrStat(8'h04, 1'b1, 1'b0);
    tick(2); expectStat("R5", 8'hBE);
    wpN = 1'b1;

    req = "R7"; wrStat(8'h04, 1'b1, 1'b1); tick(2); expectStat("R7", 8'hBE);

    req = "R8"; wrStat(8'h07, 1'b1, 1'b0);
    wpN = 1'b0; tick(3); wpN = 1'b1;
    tick(BUSY); expectStat("R8", 8'h04);

    req = "R6"; wpN = 1'b0; pulse(setWel); wrStat(8'h48, 1'b1, 1'b0);
    expectStat("R6", 8'h4B);
    tick(BUSY + 2); expectStat("R6", 8'h48);
    wpN = 1'b1; tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule